// File: doc/BRIEF.md
# Timed Interrupt Hold Controller

This block holds off maskable interrupt requests for a programmed number of instruction cycles. A hold command carries an immediate count N. The command cycle itself is masked, and the count is loaded at the end of that cycle. The count then falls by one on every enabled instruction cycle, and masking ends when it reaches zero. The total window is therefore N+1 instruction cycles. A command that arrives while a window is open restarts the window with the new count. This includes a command on the very cycle the count has just become zero, and in that case the mask never drops for a cycle.

Only one countdown exists. Software that nests hold windows reads the 14-bit count through the register port, writes its own value, and later writes the saved value back. The incoming request vector is indexed by priority level: bit i is a request at level i. Levels at or above a configurable top level bypass the mask. The gated vector goes on to the priority logic.

Top module: `irq_hold_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the count reads 0, `hold_active` is low and `irq_gated` equals `irq_req`.
- R2: `hold_active` is high in every cycle where `hold_cmd` is high, so a command with N = 0 masks exactly its own cycle and nothing after it.
- R3: A command with count N loads N at the clock edge that ends the command cycle. Then `hold_active` stays high for exactly N further enabled cycles and drops in the cycle after the count reads 0, giving a window of N+1 enabled cycles.
- R4: The count decrements by one at a clock edge only when `cycle_en` is high and the count is non-zero. With `cycle_en` low, the count and the mask are frozen.
- R5: A command while the count is non-zero reloads the count with the new N, and `hold_active` stays high through the change.
- R6: A command in the cycle where the count reads 0 after a window, or reads 1 and is about to expire, loads its N, and `hold_active` stays high with no gap.
- R7: A write on the register port (`cnt_wr_en` high, no command) loads `cnt_wr_data` at the clock edge. It takes priority over the decrement, and the value reads back on `cnt_rd_data` in the next cycle.
- R8: When `hold_cmd` and `cnt_wr_en` are high in the same cycle, the command count is loaded and the written value is discarded.
- R9: Bit i of `irq_gated` equals bit i of `irq_req` when i >= TOP_LVL (7 by default), or when `hold_active` is low. Otherwise it is 0.
- R10: The largest count, 0x3FFF, loads in full and holds the mask for 16384 enabled cycles.
- R11: With the count at 0 and no command, no request is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_en | input | 1 | Instruction cycle advance; low during stalls |
| hold_cmd | input | 1 | Hold command executes this cycle |
| hold_cnt | input | CNT_W | Immediate count N of the command |
| cnt_wr_en | input | 1 | Software write to the count |
| cnt_wr_data | input | CNT_W | Value written to the count |
| cnt_rd_data | output | CNT_W | Current count |
| irq_req | input | NUM_LVL | Requests, bit i at priority level i |
| irq_gated | output | NUM_LVL | Requests after masking |
| hold_active | output | 1 | Masking in effect this cycle |

## Verification
The bench targets a command that lands on the cycle the count has just hit zero. A design that needs a non-zero count to re-engage would drop `hold_active` for that cycle, or lose the new count entirely. It also drives commands at count 1, which exposes a decrement that wins over a load. Stalls in the middle of a window expose a count that runs on while `cycle_en` is low. Simultaneous command and software write expose the wrong priority, and a full 0x3FFF window exposes a truncated counter or an off-by-one in the N+1 length.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_DEC  = 2'd1,
    UPD_SOFT = 2'd2,
    UPD_CMD  = 2'd3
  } cnt_upd_e;

  // Update priority: command, then software write, then enabled decrement.
  function automatic cnt_upd_e pick_update(
    input logic cmd,
    input logic soft_wr,
    input logic step,
    input logic nonzero
  );
    cnt_upd_e sel;
    if (cmd)                  sel = UPD_CMD;
    else if (soft_wr)         sel = UPD_SOFT;
    else if (step && nonzero) sel = UPD_DEC;
    else                      sel = UPD_KEEP;
    return sel;
  endfunction

endpackage

// File: rtl/ihc_update_sel.sv
module ihc_update_sel
  import ihc_pkg::*;
(
  input  logic     cmd_i,
  input  logic     soft_wr_i,
  input  logic     step_i,
  input  logic     nonzero_i,
  output cnt_upd_e upd_o
);

  always_comb begin
    upd_o = pick_update(cmd_i, soft_wr_i, step_i, nonzero_i);
  end

endmodule

// File: rtl/ihc_counter.sv
module ihc_counter
  import ihc_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_upd_e         upd_i,
  input  logic [CNT_W-1:0] cmd_val_i,
  input  logic [CNT_W-1:0] soft_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nonzero_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Next-state process
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    unique case (upd_i)
      UPD_CMD:  cnt_d = cmd_val_i;
      UPD_SOFT: cnt_d = soft_val_i;
      UPD_DEC:  cnt_d = cnt_q - ONE;
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign nonzero_o = |cnt_q;

endmodule

// File: rtl/ihc_gate.sv
module ihc_gate #(
  parameter int NUM_LVL = 8,
  parameter int TOP_LVL = 7
) (
  input  logic               hold_i,
  input  logic [NUM_LVL-1:0] req_i,
  output logic [NUM_LVL-1:0] req_o
);

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    if (i >= TOP_LVL) begin : g_pass
      assign req_o[i] = req_i[i];
    end else begin : g_mask
      assign req_o[i] = req_i[i] & ~hold_i;
    end
  end

endmodule

// File: rtl/irq_hold_ctrl.sv
module irq_hold_ctrl
  import ihc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int NUM_LVL = 8,
  parameter int TOP_LVL = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycle_en,
  input  logic               hold_cmd,
  input  logic [CNT_W-1:0]   hold_cnt,
  input  logic               cnt_wr_en,
  input  logic [CNT_W-1:0]   cnt_wr_data,
  output logic [CNT_W-1:0]   cnt_rd_data,
  input  logic [NUM_LVL-1:0] irq_req,
  output logic [NUM_LVL-1:0] irq_gated,
  output logic               hold_active
);

  cnt_upd_e upd;
  logic     cnt_nz;

  ihc_update_sel u_sel (
    .cmd_i     (hold_cmd),
    .soft_wr_i (cnt_wr_en),
    .step_i    (cycle_en),
    .nonzero_i (cnt_nz),
    .upd_o     (upd)
  );

  ihc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_i      (upd),
    .cmd_val_i  (hold_cnt),
    .soft_val_i (cnt_wr_data),
    .cnt_o      (cnt_rd_data),
    .nonzero_o  (cnt_nz)
  );

  // The command cycle is masked on its own; the count covers the rest.
  assign hold_active = hold_cmd | cnt_nz;

  ihc_gate #(.NUM_LVL(NUM_LVL), .TOP_LVL(TOP_LVL)) u_gate (
    .hold_i (hold_active),
    .req_i  (irq_req),
    .req_o  (irq_gated)
  );

endmodule

// File: rtl/ihc_checker.sv
module ihc_checker #(
  parameter int CNT_W   = 14,
  parameter int NUM_LVL = 8,
  parameter int TOP_LVL = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cycle_en,
  input logic               hold_cmd,
  input logic [CNT_W-1:0]   hold_cnt,
  input logic               cnt_wr_en,
  input logic [CNT_W-1:0]   cnt_wr_data,
  input logic [CNT_W-1:0]   cnt_rd_data,
  input logic [NUM_LVL-1:0] irq_req,
  input logic [NUM_LVL-1:0] irq_gated,
  input logic               hold_active
);

  // R1: count cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (cnt_rd_data == '0);
    end
  end

  p_cmd_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cmd |-> hold_active);

  p_cmd_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cmd |=> (cnt_rd_data == $past(hold_cnt)));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_cmd && !cnt_wr_en && cycle_en && cnt_rd_data != '0)
      |=> (cnt_rd_data == $past(cnt_rd_data) - 1'b1));

  p_stall_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_cmd && !cnt_wr_en && !cycle_en) |=> $stable(cnt_rd_data));

  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cmd && hold_cnt != '0) |=> hold_active);

  p_soft_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !hold_cmd) |=> (cnt_rd_data == $past(cnt_wr_data)));

  p_idle_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_cmd && cnt_rd_data == '0) |-> (irq_gated == irq_req));

  if (TOP_LVL < NUM_LVL) begin : g_top_chk
    p_top_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_gated[NUM_LVL-1:TOP_LVL] == irq_req[NUM_LVL-1:TOP_LVL]);
  end

  if (TOP_LVL > 0) begin : g_low_chk
    localparam int LOW_HI = (TOP_LVL > NUM_LVL) ? NUM_LVL - 1 : TOP_LVL - 1;
    p_low_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (irq_gated[LOW_HI:0] == '0));
  end

endmodule

bind irq_hold_ctrl ihc_checker #(
  .CNT_W(CNT_W), .NUM_LVL(NUM_LVL), .TOP_LVL(TOP_LVL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_en    (cycle_en),
  .hold_cmd    (hold_cmd),
  .hold_cnt    (hold_cnt),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cnt_rd_data (cnt_rd_data),
  .irq_req     (irq_req),
  .irq_gated   (irq_gated),
  .hold_active (hold_active)
);

// File: tb/irq_hold_ctrl_bench.sv
module irq_hold_ctrl_bench;

  localparam int CW   = 14;
  localparam int NL   = 8;
  localparam int TOPL = 7;

  logic          clk;
  logic          rst_n;
  logic          cycle_en;
  logic          hold_cmd;
  logic [CW-1:0] hold_cnt;
  logic          cnt_wr_en;
  logic [CW-1:0] cnt_wr_data;
  logic [CW-1:0] cnt_rd_data;
  logic [NL-1:0] irq_req;
  logic [NL-1:0] irq_gated;
  logic          hold_active;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  int unsigned cyc      = 0;
  logic [CW-1:0] m_cnt;
  int unsigned seed_dummy;

  irq_hold_ctrl #(.CNT_W(CW), .NUM_LVL(NL), .TOP_LVL(TOPL)) u_irq_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cycle_en(cycle_en), .hold_cmd(hold_cmd),
    .hold_cnt(hold_cnt), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_rd_data(cnt_rd_data), .irq_req(irq_req), .irq_gated(irq_gated),
    .hold_active(hold_active)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic logic [CW-1:0] model_next(input logic c, input logic [CW-1:0] n,
      input logic s, input logic [CW-1:0] d, input logic e, input logic [CW-1:0] cur);
    if (c)                     return n;
    else if (s)                return d;
    else if (e && cur != '0)   return cur - 1'b1;
    else                       return cur;
  endfunction

  function automatic logic [NL-1:0] model_gate(input logic [NL-1:0] r, input logic h);
    logic [NL-1:0] g;
    for (int i = 0; i < NL; i++) g[i] = r[i] & (~h | (i >= TOPL));
    return g;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one instruction cycle and check its combinational outputs.
  task automatic step(input logic c, input logic [CW-1:0] n, input logic s,
      input logic [CW-1:0] d, input logic e, input logic [NL-1:0] r, input string tag);
    logic exp_h;
    @(negedge clk);
    hold_cmd = c; hold_cnt = n; cnt_wr_en = s; cnt_wr_data = d;
    cycle_en = e; irq_req = r;
    #1;
    exp_h = c | (m_cnt != '0);
    chk(tag, {31'd0, hold_active}, {31'd0, exp_h});
    chk(tag, {18'd0, cnt_rd_data}, {18'd0, m_cnt});
    chk(tag, {24'd0, irq_gated}, {24'd0, model_gate(r, exp_h)});
    m_cnt = model_next(c, n, s, d, e, m_cnt);
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(1'b0, '0, 1'b0, '0, 1'b1, 8'hFF, tag);
  endtask

  int hold_cycles;

  initial begin
    seed_dummy = $urandom(32'h1D5E_0042);
    rst_n = 1'b0; cycle_en = 1'b0; hold_cmd = 1'b0; hold_cnt = '0;
    cnt_wr_en = 1'b0; cnt_wr_data = '0; irq_req = 8'hA5;
    m_cnt = '0;
    @(negedge clk); #1;
    chk("R1 reset count", {18'd0, cnt_rd_data}, 32'd0);
    chk("R1 reset hold", {31'd0, hold_active}, 32'd0);
    chk("R1 reset gate", {24'd0, irq_gated}, 32'hA5);
    @(negedge clk); rst_n = 1'b1;

    // R11: idle passes everything
    idle(2, "R11");

    // R2: N = 0 masks the command cycle only
    step(1'b1, 14'd0, 1'b0, '0, 1'b1, 8'hFF, "R2");
    step(1'b0, 14'd0, 1'b0, '0, 1'b1, 8'hFF, "R2");
    chk("R2 after zero cmd", {31'd0, hold_active}, 32'd0);

    // R3: window length N+1
    step(1'b1, 14'd5, 1'b0, '0, 1'b1, 8'hFF, "R3");
    hold_cycles = 1;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, '0, 1'b0, '0, 1'b1, 8'hFF, "R3");
      if (hold_active) hold_cycles++;
    end
    chk("R3 window length", hold_cycles, 32'd6);

    // R4: stall freezes the count
    step(1'b1, 14'd3, 1'b0, '0, 1'b1, 8'h7F, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, '0, 1'b0, 8'h7F, "R4");
    chk("R4 frozen count", {18'd0, cnt_rd_data}, 32'd3);
    idle(4, "R4");

    // R5: reload while non-zero
    step(1'b1, 14'd6, 1'b0, '0, 1'b1, 8'hFF, "R5");
    idle(2, "R5");
    step(1'b1, 14'd2, 1'b0, '0, 1'b1, 8'hFF, "R5");
    step(1'b0, '0, 1'b0, '0, 1'b1, 8'hFF, "R5");
    chk("R5 reloaded", {18'd0, cnt_rd_data}, 32'd2);
    idle(3, "R5");

    // R6: command on the cycle the count reads zero
    step(1'b1, 14'd2, 1'b0, '0, 1'b1, 8'hFF, "R6");
    idle(2, "R6");
    step(1'b1, 14'd4, 1'b0, '0, 1'b1, 8'hFF, "R6");
    chk("R6 no gap at zero", {31'd0, hold_active}, 32'd1);
    idle(3, "R6");
    step(1'b1, 14'd3, 1'b0, '0, 1'b1, 8'hFF, "R6");
    step(1'b0, '0, 1'b0, '0, 1'b1, 8'hFF, "R6");
    chk("R6 count at one", {18'd0, cnt_rd_data}, 32'd3);
    idle(5, "R6");

    // R7: software write beats decrement
    step(1'b1, 14'd3, 1'b0, '0, 1'b1, 8'hFF, "R7");
    step(1'b0, '0, 1'b1, 14'd9, 1'b1, 8'hFF, "R7");
    step(1'b0, '0, 1'b0, '0, 1'b0, 8'hFF, "R7");
    chk("R7 readback", {18'd0, cnt_rd_data}, 32'd9);
    step(1'b0, '0, 1'b1, 14'd0, 1'b1, 8'hFF, "R7");

    // R8: command beats software write
    step(1'b1, 14'd4, 1'b1, 14'd11, 1'b1, 8'hFF, "R8");
    step(1'b0, '0, 1'b0, '0, 1'b0, 8'hFF, "R8");
    chk("R8 cmd wins", {18'd0, cnt_rd_data}, 32'd4);

    // R9: top level passes while held
    step(1'b0, '0, 1'b0, '0, 1'b0, 8'hFF, "R9");
    chk("R9 top pass", {24'd0, irq_gated}, 32'h80);
    idle(5, "R9");

    // R10: full-scale count
    step(1'b1, 14'h3FFF, 1'b0, '0, 1'b1, 8'h01, "R10");
    hold_cycles = 1;
    for (int i = 0; i < 16386; i++) begin
      step(1'b0, '0, 1'b0, '0, 1'b1, 8'h01, "R10");
      if (hold_active) hold_cycles++;
    end
    chk("R10 full window", hold_cycles, 32'd16384);

    // Random mix, all requirements against the model
    for (int i = 0; i < 4000; i++) begin
      logic c, s, e;
      logic [CW-1:0] n, d;
      c = ($urandom_range(0, 7) == 0);
      s = ($urandom_range(0, 11) == 0);
      e = ($urandom_range(0, 3) != 0);
      n = CW'($urandom_range(0, 12));
      d = CW'($urandom_range(0, 12));
      step(c, n, s, d, e, NL'($urandom), "R5 R6 R7 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule